// File: doc/BRIEF.md
# Serial Threshold Offset Loader

This block sets up the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Both offsets are loaded over a single serial line. A bit is taken on every rising clock edge where both the serial enable and the load select are high. The first W bits go into the empty-side offset, least significant bit first. The next W bits go into the full-side offset in the same order. W is the offset width, which is the top bit index plus one.

The position within the 2W-bit stream is kept across idle cycles, so a load may stop and later resume. After the last full-side bit the position wraps, and the next bit lands again in bit 0 of the empty-side offset. A one-cycle completion pulse marks the capture of the final full-side bit. An active-low reset restores both offsets to parameterised defaults and moves the position back to the start of the empty-side offset.

Top module: `offset_serial_loader`

## Requirements
- R1: While reset is low, and after it is released with no capture, empty_offset equals EMPTY_INIT (default 16'h003F), full_offset equals FULL_INIT (default 16'h00C0), and load_done is 0.
- R2: A bit is captured only on a rising edge with both shift_en and load_sel high. On any other edge, neither offset changes.
- R3: Counting from reset or from a wrap, the k-th captured bit (k = 0..W-1) is written to empty_offset bit k. No other bit of either offset changes.
- R4: Captured bits W..2W-1 are written to full_offset bits 0..W-1 in order. empty_offset does not change while they are taken.
- R5: Edges without a capture leave the stream position unchanged, so the next captured bit goes to the position that follows the last one taken.
- R6: load_done is high for exactly the one cycle that follows the edge capturing full_offset bit W-1, and is low at all other times.
- R7: The bit captured after full_offset bit W-1 is written to empty_offset bit 0, and loading continues from there.
- R8: A reset in the middle of a load restores the defaults, and the next captured bit goes to empty_offset bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock; captures occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| shift_en | input | 1 | Serial enable |
| load_sel | input | 1 | Load select; must be high together with shift_en to capture |
| ser_bit | input | 1 | Serial data bit |
| empty_offset | output | MSB_IDX+1 | Almost-empty threshold offset |
| full_offset | output | MSB_IDX+1 | Almost-full threshold offset |
| load_done | output | 1 | One-cycle pulse after the last full-offset bit is taken |

## Verification
The completion pulse and the wrap back to empty_offset bit 0 can fall on the same edge. This happens when the serial stream continues without a gap from the last full-side bit into a new empty-side word. The edge that takes that next bit clears load_done and writes empty_offset bit 0 at once. The bench provokes this by running consecutive table rows with both enables held high. It then judges each sample separately: load_done must be high only at the sample after bit 2W-1, and empty_offset bit 0 must take the new value one sample later, while full_offset stays unchanged.

// File: rtl/offload_pkg.sv
package offload_pkg;

   typedef enum logic {
      TGT_EMPTY = 1'b0,
      TGT_FULL  = 1'b1
   } offload_tgt_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/offload_pos_counter.sv
module offload_pos_counter #(
   parameter int unsigned W  = 16,
   parameter int unsigned CW = 5,
   parameter int unsigned IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output offload_pkg::offload_tgt_e tgt,
   output logic [IW-1:0] bit_idx,
   output logic          at_last
);
   localparam logic [CW-1:0] LAST_POS = CW'(2 * W - 1);

   logic [CW-1:0] pos;

   assign at_last = (pos == LAST_POS);

   generate
      if (offload_pkg::is_pow2(W)) begin : g_pow2
         // 2W fills the counter exactly: natural wrap, top bit picks the target
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pos <= '0;
            else if (step) pos <= pos + 1'b1;
         end
         assign tgt     = offload_pkg::offload_tgt_e'(pos[CW-1]);
         assign bit_idx = pos[IW-1:0];
      end else begin : g_gen
         logic          in_full;
         logic [CW-1:0] rel;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pos <= '0;
            else if (step) pos <= at_last ? '0 : pos + 1'b1;
         end
         assign in_full = (pos >= CW'(W));
         assign rel     = in_full ? pos - CW'(W) : pos;
         assign tgt     = in_full ? offload_pkg::TGT_FULL : offload_pkg::TGT_EMPTY;
         assign bit_idx = rel[IW-1:0];
      end
   endgenerate
endmodule

// File: rtl/offload_bit_reg.sv
module offload_bit_reg #(
   parameter int unsigned   W    = 16,
   parameter int unsigned   IW   = 4,
   parameter logic [W-1:0]  INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [IW-1:0] idx,
   input  logic          din,
   output logic [W-1:0]  q
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q[i] <= INIT[i];
            else if (wr && (idx == IW'(i)))    q[i] <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/offset_serial_loader.sv
module offset_serial_loader #(
   parameter int unsigned         MSB_IDX    = 15,
   parameter logic [MSB_IDX:0]    EMPTY_INIT = 'h003F,
   parameter logic [MSB_IDX:0]    FULL_INIT  = 'h00C0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             load_sel,
   input  logic             ser_bit,
   output logic [MSB_IDX:0] empty_offset,
   output logic [MSB_IDX:0] full_offset,
   output logic             load_done
);
   localparam int unsigned W  = MSB_IDX + 1;
   localparam int unsigned CW = offload_pkg::clog2_min1(2 * W);
   localparam int unsigned IW = offload_pkg::is_pow2(W) ? CW - 1
                                                        : offload_pkg::clog2_min1(W);
   localparam logic [1:0][W-1:0] INITS = {FULL_INIT, EMPTY_INIT};

   generate
      if (MSB_IDX < 1) begin : g_bad_width
         $error("offset_serial_loader: MSB_IDX must be at least 1");
      end
   endgenerate

   logic                      cap;
   logic                      at_last;
   logic [IW-1:0]             bit_idx;
   offload_pkg::offload_tgt_e tgt;
   logic [1:0][W-1:0]         regs;

   assign cap = shift_en & load_sel;

   offload_pos_counter #(.W(W), .CW(CW), .IW(IW)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (cap),
      .tgt     (tgt),
      .bit_idx (bit_idx),
      .at_last (at_last)
   );

   generate
      for (genvar r = 0; r < 2; r++) begin : g_reg
         offload_bit_reg #(.W(W), .IW(IW), .INIT(INITS[r])) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (cap && (tgt == offload_pkg::offload_tgt_e'(r))),
            .idx   (bit_idx),
            .din   (ser_bit),
            .q     (regs[r])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_done <= 1'b0;
      else        load_done <= cap && at_last;
   end

   assign empty_offset = regs[0];
   assign full_offset  = regs[1];
endmodule

// File: rtl/offset_serial_loader_props.sv
module offset_serial_loader_props #(
   parameter int unsigned MSB_IDX = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             shift_en,
   input logic             load_sel,
   input logic [MSB_IDX:0] empty_offset,
   input logic [MSB_IDX:0] full_offset,
   input logic             load_done
);
   assert_idle_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_en && load_sel) |=> ($stable(empty_offset) && $stable(full_offset)));

   assert_one_bit_per_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(empty_offset ^ $past(empty_offset)) +
       $countones(full_offset ^ $past(full_offset))) <= 1);

   assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(full_offset) |-> $stable(empty_offset));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> !load_done);

   assert_done_after_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> $past(shift_en && load_sel));

   assert_wrap_to_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && shift_en && load_sel) |=>
         ($stable(full_offset) && (empty_offset[MSB_IDX:1] == $past(empty_offset[MSB_IDX:1]))));
endmodule

bind offset_serial_loader offset_serial_loader_props #(.MSB_IDX(MSB_IDX)) u_props (
   .clk          (clk),
   .rst_n        (rst_n),
   .shift_en     (shift_en),
   .load_sel     (load_sel),
   .empty_offset (empty_offset),
   .full_offset  (full_offset),
   .load_done    (load_done)
);

// File: tb/offset_serial_loader_test.sv
`timescale 1ns/1ps
module offset_serial_loader_test;
   localparam int W = 16;
   localparam logic [W-1:0] E_DEF = 16'h003F;
   localparam logic [W-1:0] F_DEF = 16'h00C0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_en = 1'b0;
   logic load_sel = 1'b0;
   logic ser_bit = 1'b0;
   logic [W-1:0] empty_offset, full_offset;
   logic load_done;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // model state
   int mpos = 0;
   logic [W-1:0] me = E_DEF;
   logic [W-1:0] mf = F_DEF;

   always #2 clk = ~clk;

   offset_serial_loader uut (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load_sel(load_sel),
      .ser_bit(ser_bit), .empty_offset(empty_offset), .full_offset(full_offset),
      .load_done(load_done)
   );

   // row: {en, ld, data, expected empty, expected full}
   localparam int NROWS = 6;
   localparam logic [49:0] ROWS [NROWS] = '{
      {1'b1, 1'b1, 16'hA5C3, 16'hA5C3, 16'h00C0},  // R3 empty fill
      {1'b0, 1'b1, 16'hFFFF, 16'hA5C3, 16'h00C0},  // R2 shift_en low
      {1'b1, 1'b0, 16'hFFFF, 16'hA5C3, 16'h00C0},  // R2 load_sel low
      {1'b1, 1'b1, 16'h1234, 16'hA5C3, 16'h1234},  // R4 full fill, R6 done
      {1'b1, 1'b1, 16'h0F0F, 16'h0F0F, 16'h1234},  // R7 wrap to empty
      {1'b1, 1'b1, 16'h8001, 16'h0F0F, 16'h8001}   // R4 R6 second pass
   };
   string row_tag [NROWS] = '{"R3", "R2", "R2", "R4 R6", "R7", "R4 R6"};

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic en, input logic ld, input logic b, input string req);
      logic exp_done;
      @(negedge clk);
      shift_en = en; load_sel = ld; ser_bit = b;
      @(posedge clk);
      #1;
      exp_done = 1'b0;
      if (en && ld) begin
         if (mpos < W) me[mpos] = b;
         else          mf[mpos - W] = b;
         exp_done = (mpos == 2 * W - 1);
         mpos = (mpos + 1) % (2 * W);
      end
      check(load_done === exp_done, req, "load_done", W'(load_done), W'(exp_done));
      check(empty_offset === me, req, "empty_offset per bit", empty_offset, me);
      check(full_offset === mf, req, "full_offset per bit", full_offset, mf);
   endtask

   task automatic do_reset();
      @(negedge clk);
      shift_en = 1'b0; load_sel = 1'b0; rst_n = 1'b0;
      #1;
      mpos = 0; me = E_DEF; mf = F_DEF;
      check(empty_offset === E_DEF, "R1", "empty in reset", empty_offset, E_DEF);
      check(full_offset === F_DEF, "R1", "full in reset", full_offset, F_DEF);
      check(load_done === 1'b0, "R1", "done in reset", W'(load_done), '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pw;
      repeat (3) @(negedge clk);
      do_reset();
      @(negedge clk);
      #1;
      check(empty_offset === E_DEF, "R1", "empty after release", empty_offset, E_DEF);
      check(full_offset === F_DEF, "R1", "full after release", full_offset, F_DEF);

      // table walk
      for (int r = 0; r < NROWS; r++) begin
         logic [49:0] v;
         v = ROWS[r];
         for (int k = 0; k < W; k++) send(v[49], v[48], v[32 + k], row_tag[r]);
         check(empty_offset === v[31:16], row_tag[r], "row empty", empty_offset, v[31:16]);
         check(full_offset === v[15:0], row_tag[r], "row full", full_offset, v[15:0]);
      end

      // R5: pause mid-word, then resume
      pw = 16'hC3A5;
      for (int k = 0; k < 5; k++) send(1'b1, 1'b1, pw[k], "R5");
      send(1'b1, 1'b0, 1'b1, "R5");
      send(1'b0, 1'b1, 1'b0, "R5");
      send(1'b0, 1'b0, 1'b1, "R5");
      for (int k = 5; k < W; k++) send(1'b1, 1'b1, pw[k], "R5");
      check(empty_offset === 16'hC3A5, "R5", "resumed word", empty_offset, 16'hC3A5);
      check(full_offset === 16'h8001, "R5", "full untouched", full_offset, 16'h8001);

      // R8: reset mid full-offset load, then restart
      for (int k = 0; k < 7; k++) send(1'b1, 1'b1, 1'b1, "R8");
      check(full_offset === 16'h807F, "R8", "partial full", full_offset, 16'h807F);
      do_reset();
      pw = 16'h5A5A;
      for (int k = 0; k < W; k++) send(1'b1, 1'b1, pw[k], "R8");
      check(empty_offset === 16'h5A5A, "R8", "restart at empty bit 0", empty_offset, 16'h5A5A);
      check(full_offset === F_DEF, "R8", "full stays default", full_offset, F_DEF);

      @(negedge clk);
      shift_en = 1'b0; load_sel = 1'b0;
      finished = 1;
      summary();
      $finish;
   end
endmodule